// File: doc/BRIEF.md
# Timer Interrupt Pacer with Acknowledge Gating

This block sits between the expiry output of a timer channel and the interrupt line of a processor. Timer expiries are not passed straight through. Each expiry adds one to a pending count. The block then sends a single one-cycle interrupt pulse and waits. It sends the next pulse only after the previous one has been acknowledged, or after a configurable number of time units has passed since the last pulse. Expiries that arrive while the processor is busy therefore merge into the count instead of being lost. The processor is also never flooded with back-to-back interrupts.

Two interrupt controllers can deliver the pulse. Each controller has a vector number and a mask bit. An acknowledge is a delivered-vector report. It is accepted only when the vector belongs to an unmasked controller and work is pending. An accepted acknowledge removes one unit of pending work, re-enables issuing, and sends a one-cycle restart strobe back to the timer channel so that its count timing starts again. Loading a new count into the channel discards all pending work. The counting mode given with the load decides how expiries are treated afterwards: they can be counted repeatedly, counted only once, or ignored.

Top module: `irq_pacer`

## Requirements
- R1: One cycle after reset is released, `pend_nz`, `irq_out` and `restart_out` are 0, and expiries are ignored until the first load. The acknowledged state starts true, so the first pending unit after a load can issue without waiting for an acknowledge.
- R2: After a load with `load_mode` 2 or 3, every cycle with `tick_in` high adds one to the pending count.
- R3: After a load with `load_mode` 1 or 4, only the first `tick_in` after that load is counted. Later ticks are ignored until the next load.
- R4: After a load with any other `load_mode` value (0, 5, 6, 7), `tick_in` is ignored.
- R5: A cycle with `load_in` high sets the pending count to zero on the next edge. A tick in that same cycle is not counted.
- R6: The pending count saturates at 2^PEND_W-1 instead of wrapping.
- R7: An interrupt is issued only while the pending count is nonzero and either the acknowledged state is true or the time since the last issue has reached `max_gap`. Each issue drives `irq_out` high for exactly one cycle, one edge after the issue decision, and clears the acknowledged state. A tick counted at edge k therefore raises `irq_out` after edge k+1.
- R8: While work is pending and no acknowledge arrives, `irq_out` pulses repeat with a spacing of exactly `max_gap` cycles when `now_time` advances by one each cycle.
- R9: An acknowledge is accepted only when `ack_valid` is high, the pending count is nonzero, and `ack_vec` equals `ctl_a_vec` while `ctl_a_mask` is 0, or equals `ctl_b_vec` while `ctl_b_mask` is 0. Any other acknowledge has no effect.
- R10: An accepted acknowledge removes one from the pending count, sets the acknowledged state, and raises `restart_out` for one cycle after the next edge.
- R11: A counted tick and an accepted acknowledge in the same cycle leave the pending count unchanged. `restart_out` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Timer channel expiry, one cycle per expiry |
| load_in | input | 1 | A new count was loaded into the channel |
| load_mode | input | 3 | Counting mode that accompanies the load |
| ack_valid | input | 1 | A vector was delivered this cycle |
| ack_vec | input | VEC_W | Number of the delivered vector |
| ctl_a_vec | input | VEC_W | Vector that controller A uses for this line |
| ctl_a_mask | input | 1 | Controller A has this line masked |
| ctl_b_vec | input | VEC_W | Vector that controller B uses for this line |
| ctl_b_mask | input | 1 | Controller B has this line masked |
| now_time | input | TIME_W | Free-running time counter |
| max_gap | input | TIME_W | Time after which an unacknowledged interrupt is issued again |
| irq_out | output | 1 | One-cycle interrupt pulse to both controllers |
| pend_nz | output | 1 | Pending count is nonzero |
| restart_out | output | 1 | Strobe that restarts the channel count timing |

## Verification
The bench sends twenty ticks and then exactly fourteen accepted acknowledges. A counter that wraps instead of saturating would reach zero far too early. It drives an acknowledge with the right vector to the masked controller, and an acknowledge while nothing is pending. A design that ignores the mask bit or the pending check would lower `pend_nz` or pulse `restart_out` when it should not. It drives a tick together with an accepted acknowledge, and a tick together with a load. These expose a counter that gives one of the inputs priority, or one that counts a tick during a load. It also measures the spacing between repeated unacknowledged pulses, which catches an off-by-one in the timeout comparison. Finally, it checks that one-shot and stopped modes count the right number of ticks.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;
    localparam int NUM_CTL = 2;

    // How expiries are treated after a load
    typedef enum logic [1:0] {
        TC_STOP   = 2'd0,
        TC_ONCE   = 2'd1,
        TC_REPEAT = 2'd2
    } tclass_e;

    // Routing of this line inside one interrupt controller
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             masked;
    } ctl_route_t;

    function automatic tclass_e classify(input logic [MODE_W-1:0] m);
        tclass_e c;
        case (m)
            MODE_W'(1), MODE_W'(4): c = TC_ONCE;
            MODE_W'(2), MODE_W'(3): c = TC_REPEAT;
            default:                c = TC_STOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pacer_tick_gate.sv
module pacer_tick_gate
    import pacer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              load_in,
    input  logic [MODE_W-1:0] load_mode,
    output logic              tick_ok
);

    tclass_e cls_q;
    logic    armed_q;

    assign tick_ok = tick_in && armed_q && !load_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q   <= TC_STOP;
            armed_q <= 1'b0;
        end else if (load_in) begin
            cls_q   <= classify(load_mode);
            armed_q <= (classify(load_mode) != TC_STOP);
        end else if (tick_ok && cls_q == TC_ONCE) begin
            armed_q <= 1'b0;
        end
    end

    AST_ONE_SHOT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (tick_ok && cls_q == TC_ONCE) |=> !tick_ok); // R3

endmodule

// File: rtl/pacer_pend_ctr.sv
module pacer_pend_ctr #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] pend_q,
    output logic              nz
);

    localparam logic [PEND_W-1:0] MAXV = '1;

    assign nz = (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= '0;
        end else if (inc && !dec) begin
            if (pend_q != MAXV) pend_q <= pend_q + 1'b1;
        end else if (dec && !inc) begin
            if (pend_q != '0) pend_q <= pend_q - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && !dec && pend_q == MAXV) |=> (pend_q == MAXV)); // R6

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend_q == '0)); // R5

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && dec) |=> $stable(pend_q)); // R11

endmodule

// File: rtl/pacer_ack_match.sv
module pacer_ack_match
    import pacer_pkg::*;
(
    input  logic                       ack_valid,
    input  logic [VEC_W-1:0]           ack_vec,
    input  logic                       pend_nz,
    input  ctl_route_t [NUM_CTL-1:0]   routes,
    output logic                       ack_ok
);

    logic [NUM_CTL-1:0] hit;

    for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
        assign hit[i] = !routes[i].masked && (routes[i].vec == ack_vec);
    end

    assign ack_ok = ack_valid && pend_nz && (|hit);

endmodule

// File: rtl/pacer_inject.sv
module pacer_inject #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_nz,
    input  logic              ack_ok,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] max_gap,
    output logic              irq_q,
    output logic              restart_q
);

    logic              acked_q;
    logic [TIME_W-1:0] last_q;
    logic [TIME_W-1:0] gap;
    logic              fire;

    assign gap  = now_time - last_q;
    assign fire = pend_nz && (acked_q || (gap >= max_gap));

    always_ff @(posedge clk) begin
        if (rst) begin
            acked_q   <= 1'b1;
            last_q    <= '0;
            irq_q     <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            irq_q     <= fire;
            restart_q <= ack_ok;
            if (fire) last_q <= now_time;
            if (ack_ok)    acked_q <= 1'b1;
            else if (fire) acked_q <= 1'b0;
        end
    end

    AST_PULSE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(pend_nz)); // R7

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
    import pacer_pkg::*;
#(
    parameter int PEND_W = 4,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              load_in,
    input  logic [MODE_W-1:0] load_mode,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vec,
    input  logic [VEC_W-1:0]  ctl_a_vec,
    input  logic              ctl_a_mask,
    input  logic [VEC_W-1:0]  ctl_b_vec,
    input  logic              ctl_b_mask,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] max_gap,
    output logic              irq_out,
    output logic              pend_nz,
    output logic              restart_out
);

    logic                     tick_ok;
    logic                     ack_ok;
    logic [PEND_W-1:0]        pend_q;
    ctl_route_t [NUM_CTL-1:0] routes;

    assign routes[0] = '{vec: ctl_a_vec, masked: ctl_a_mask};
    assign routes[1] = '{vec: ctl_b_vec, masked: ctl_b_mask};

    pacer_tick_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .tick_in   (tick_in),
        .load_in   (load_in),
        .load_mode (load_mode),
        .tick_ok   (tick_ok)
    );

    pacer_ack_match u_match (
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .pend_nz   (pend_nz),
        .routes    (routes),
        .ack_ok    (ack_ok)
    );

    pacer_pend_ctr #(.PEND_W(PEND_W)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .clr    (load_in),
        .inc    (tick_ok),
        .dec    (ack_ok),
        .pend_q (pend_q),
        .nz     (pend_nz)
    );

    pacer_inject #(.TIME_W(TIME_W)) u_inj (
        .clk       (clk),
        .rst       (rst),
        .pend_nz   (pend_nz),
        .ack_ok    (ack_ok),
        .now_time  (now_time),
        .max_gap   (max_gap),
        .irq_q     (irq_out),
        .restart_q (restart_out)
    );

    AST_RESTART_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        restart_out |-> ($past(ack_valid) && $past(pend_nz))); // R10

    AST_PENDING_FALLS_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_nz) |-> ($past(load_in) || $past(ack_valid))); // R9

endmodule

// File: tb/irq_pacer_test.sv
module irq_pacer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PEND_W = 4;
    localparam int TIME_W = 16;
    localparam int BIG_GAP = 1000;
    localparam logic [7:0] VA = 8'h20;
    localparam logic [7:0] VB = 8'h30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_in = 1'b0, load_in = 1'b0, ack_valid = 1'b0;
    logic [2:0] load_mode = 3'd0;
    logic [7:0] ack_vec = 8'h00;
    logic [7:0] ctl_a_vec = VA, ctl_b_vec = VB;
    logic ctl_a_mask = 1'b0, ctl_b_mask = 1'b1;
    logic [TIME_W-1:0] now_time = '0;
    logic [TIME_W-1:0] max_gap = TIME_W'(BIG_GAP);
    logic irq_out, pend_nz, restart_out;

    int n_chk = 0, n_fail = 0;
    int irq_cnt = 0, edge_no = 0, last_irq_at = 0, prev_irq_at = 0;
    bit finished = 1'b0;

    irq_pacer #(.PEND_W(PEND_W), .TIME_W(TIME_W)) uut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .load_in(load_in),
        .load_mode(load_mode), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .ctl_a_vec(ctl_a_vec), .ctl_a_mask(ctl_a_mask),
        .ctl_b_vec(ctl_b_vec), .ctl_b_mask(ctl_b_mask),
        .now_time(now_time), .max_gap(max_gap),
        .irq_out(irq_out), .pend_nz(pend_nz), .restart_out(restart_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) now_time <= now_time + 1'b1;

    always @(posedge clk) begin
        edge_no <= edge_no + 1;
        if (irq_out) begin
            irq_cnt     <= irq_cnt + 1;
            prev_irq_at <= last_irq_at;
            last_irq_at <= edge_no;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [2:0] m);
        load_in = 1'b1; load_mode = m; cyc(); load_in = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        tick_in = 1'b1; cyc(n); tick_in = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] v);
        ack_valid = 1'b1; ack_vec = v; cyc(); ack_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pend_nz after reset", pend_nz, 0);
        chk("R1 irq_out after reset", irq_out, 0);
        chk("R1 restart_out after reset", restart_out, 0);
        do_ticks(2);
        chk("R1 ticks before first load ignored", pend_nz, 0);
    endtask

    task automatic t_periodic();
        int base;
        do_load(3'd2);
        base = irq_cnt;
        do_ticks(1);
        chk("R2 tick counted in mode 2", pend_nz, 1);
        cyc();
        chk("R7 irq_out high one edge after pending", irq_out, 1);
        cyc();
        chk("R7 irq_out is a one-cycle pulse", irq_out, 0);
        cyc(6);
        chk("R7 no second pulse before acknowledge", irq_cnt - base, 1);
    endtask

    task automatic t_timeout();
        max_gap = TIME_W'(6);
        cyc(25);
        chk("R8 repeat spacing equals max_gap", last_irq_at - prev_irq_at, 6);
        max_gap = TIME_W'(BIG_GAP);
        cyc(3);
    endtask

    task automatic t_ack_filter();
        do_ack(8'h55);
        chk("R9 wrong vector leaves pending", pend_nz, 1);
        chk("R9 wrong vector gives no restart", restart_out, 0);
        do_ack(VB);
        chk("R9 masked controller vector ignored", pend_nz, 1);
        chk("R9 masked controller no restart", restart_out, 0);
        do_ack(VA);
        chk("R10 valid ack restarts channel", restart_out, 1);
        chk("R10 valid ack removes pending", pend_nz, 0);
        cyc();
        chk("R10 restart is one cycle", restart_out, 0);
        do_ack(VA);
        chk("R9 ack with nothing pending ignored", restart_out, 0);
    endtask

    task automatic t_coalesce();
        int base;
        ctl_a_mask = 1'b1; ctl_b_mask = 1'b0;
        do_load(3'd3);
        base = irq_cnt;
        do_ticks(3);
        cyc(6);
        chk("R2 mode 3 ticks pending", pend_nz, 1);
        chk("R7 merged ticks give one pulse", irq_cnt - base, 1);
        do_ack(VB); cyc(5);
        do_ack(VB); cyc(5);
        chk("R10 two of three acks leave pending", pend_nz, 1);
        do_ack(VB);
        chk("R10 third ack empties pending", pend_nz, 0);
        cyc(5);
        chk("R10 one pulse per accepted ack", irq_cnt - base, 3);
        ctl_a_mask = 1'b0; ctl_b_mask = 1'b1;
    endtask

    task automatic t_saturate();
        do_load(3'd2);
        do_ticks(20);
        cyc(2);
        for (int i = 0; i < 14; i++) begin
            do_ack(VA);
            cyc(3);
        end
        chk("R6 count held at maximum", pend_nz, 1);
        do_ack(VA);
        chk("R6 fifteenth ack empties", pend_nz, 0);
    endtask

    task automatic t_oneshot();
        do_load(3'd1);
        do_ticks(1); cyc(2); do_ticks(1); cyc(2); do_ticks(1); cyc(2);
        chk("R3 mode 1 pending", pend_nz, 1);
        do_ack(VA);
        chk("R3 mode 1 counted one tick", pend_nz, 0);
        do_ticks(1);
        chk("R3 later tick ignored", pend_nz, 0);
        do_load(3'd4);
        do_ticks(2); cyc(3);
        do_ack(VA);
        chk("R3 mode 4 counted one tick", pend_nz, 0);
    endtask

    task automatic t_stop();
        do_load(3'd5); do_ticks(2);
        chk("R4 mode 5 ignores ticks", pend_nz, 0);
        do_load(3'd0); do_ticks(2);
        chk("R4 mode 0 ignores ticks", pend_nz, 0);
        do_load(3'd7); do_ticks(2);
        chk("R4 mode 7 ignores ticks", pend_nz, 0);
    endtask

    task automatic t_same_cycle();
        do_load(3'd2);
        do_ticks(1);
        cyc(3);
        tick_in = 1'b1; ack_valid = 1'b1; ack_vec = VA;
        cyc();
        tick_in = 1'b0; ack_valid = 1'b0;
        chk("R11 tick with ack keeps pending", pend_nz, 1);
        chk("R11 restart still pulses", restart_out, 1);
        cyc(2);
        do_ack(VA);
        chk("R11 count was one", pend_nz, 0);
    endtask

    task automatic t_load_clear();
        do_load(3'd2);
        do_ticks(2);
        chk("R5 pending before reload", pend_nz, 1);
        load_in = 1'b1; load_mode = 3'd2; tick_in = 1'b1;
        cyc();
        load_in = 1'b0; tick_in = 1'b0;
        chk("R5 load clears pending", pend_nz, 0);
        cyc();
        chk("R5 tick during load not counted", pend_nz, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc();
        t_reset();
        t_periodic();
        t_timeout();
        t_ack_filter();
        t_coalesce();
        t_saturate();
        t_oneshot();
        t_stop();
        t_same_cycle();
        t_load_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule